// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block is the state machine that decides which oscillator clocks a small microcontroller and how far the chip is powered down. It manages two oscillators, a fast main one and a slow sub one. It moves through reset, oscillator wait, main-clock run, sub-clock run, a pending switch back to the main clock, sleep and stop. Whenever an oscillator has to be started, it counts a parameterised number of pulses from a free-running timebase before it lets any clock reach the CPU.

Software controls the block through one write strobe. The strobe carries three request bits: clock select, sleep and stop. Interrupt requests wake the block from sleep and stop. Three level reset sources (external, software and watchdog) force the reset state from any state. The outputs drive the oscillator enables and the CPU and peripheral clock gates. They also report the selected-clock status bit and the current state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 0 (RESET), every enable output is 0 and scm_o is 0. The state codes are RESET=0, MAIN_WAIT=1, SUB_WAIT=2, MAIN_RUN=3, SUB_RUN=4, SWITCH=5, SLEEP=6, STOP=7.
- R2: One clock after leaving RESET with no reset request high, the state is MAIN_WAIT when por_sub_i is 0 and SUB_WAIT when por_sub_i is 1.
- R3: A wait state (MAIN_WAIT, SUB_WAIT or SWITCH) counts the tick_i pulses seen at clock edges while the block is in that state. The count starts again from zero on each entry. The block leaves the wait state on the clock after the pulse that brings the count to MAIN_STAB_TICKS (SUB_STAB_TICKS in SUB_WAIT). MAIN_WAIT and SUB_WAIT keep the CPU and peripheral clocks gated.
- R4: If ext_rst_i, sw_rst_i or wdt_rst_i is high at a clock edge, the next state is RESET from any state and scm_o clears. This cancels a pending switch. The block stays in RESET while any reset request remains high.
- R5: In MAIN_RUN, a write with the clock-select bit at 0 (and no sleep or stop bit) moves the block to SUB_RUN on the next clock and clears scm_o.
- R6: In SUB_RUN, a write with the clock-select bit at 1 moves the block to SWITCH. In SWITCH the CPU keeps running and both oscillators are on. scm_o stays 0 until the main delay ends, and then the block enters MAIN_RUN with scm_o at 1. SUB_RUN never goes straight to MAIN_RUN.
- R7: scm_o is 1 whenever the state is MAIN_RUN. It keeps its value through SLEEP, STOP and the wait that follows stop.
- R8: A write with the sleep bit in either run state enters SLEEP. In SLEEP the CPU clock is gated while the peripheral clock and the oscillator of the previous run mode stay on. An interrupt returns the block to that same run state.
- R9: A write with the stop bit in either run state enters STOP, where both oscillators and both clock gates are off. An interrupt leads to MAIN_WAIT if scm_o is 1 and to SUB_WAIT otherwise. The CPU clock stays off until that delay ends.
- R10: Within one write, stop wins over sleep, and either of them wins over clock select. Requests act once: after waking, the block does not re-enter sleep or stop without a new write.
- R11: Writes outside MAIN_RUN and SUB_RUN, interrupts outside SLEEP and STOP, and tick_i outside the wait states have no effect.
- R12: cpu_clk_en_o is 1 in MAIN_RUN, SUB_RUN and SWITCH. per_clk_en_o is 1 in those states and in SLEEP. main_osc_en_o is 1 in MAIN_WAIT, MAIN_RUN and SWITCH, and in SLEEP when scm_o is 1. sub_osc_en_o is 1 in SUB_WAIT, SUB_RUN and SWITCH, and in SLEEP when scm_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | Timebase pulse used to measure stabilization |
| por_sub_i | input | 1 | Target after reset: 0 main clock, 1 sub clock |
| ext_rst_i | input | 1 | External reset request, level |
| sw_rst_i | input | 1 | Software reset request, level |
| wdt_rst_i | input | 1 | Watchdog reset request, level |
| wr_i | input | 1 | Mode-control write strobe |
| wr_scs_i | input | 1 | Clock-select bit: 1 main, 0 sub |
| wr_slp_i | input | 1 | Sleep request bit |
| wr_stp_i | input | 1 | Stop request bit |
| irq_i | input | 1 | Any enabled interrupt request |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| scm_o | output | 1 | Selected clock status: 1 main, 0 sub |
| state_o | output | 3 | Current state code |

## Verification
The assertions treat the three reset requests as synchronous levels that are sampled at the clock edge. They count a request as a reset whether it lasts one cycle or many. The wake assertion also assumes that the interrupt request is a level the block samples, with no handshake back to its source.

The bench changes every input, rst_ni included, only at the falling clock edge, so each value is stable at the edge where it counts. The random phase keeps reset requests rare so that the run, sleep, stop and switch paths are all reached between resets. Tick gaps are random, which shows that the delays are measured in pulses and not in clock cycles.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    ST_RESET     = 3'd0,
    ST_MAIN_WAIT = 3'd1,
    ST_SUB_WAIT  = 3'd2,
    ST_MAIN_RUN  = 3'd3,
    ST_SUB_RUN   = 3'd4,
    ST_SWITCH    = 3'd5,
    ST_SLEEP     = 3'd6,
    ST_STOP      = 3'd7
  } pmc_state_e;
endpackage

// File: rtl/pmc_stab_cnt.sv
module pmc_stab_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  // clears whenever no wait state is active, saturates at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_gate_dec.sv
module pmc_gate_dec
  import pwr_mode_pkg::*;
(
  input  pmc_state_e state_i,
  input  logic       scm_i,
  output logic       main_osc_en_o,
  output logic       sub_osc_en_o,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o
);
  logic sleeping;

  assign sleeping      = (state_i == ST_SLEEP);
  assign cpu_clk_en_o  = (state_i == ST_MAIN_RUN) || (state_i == ST_SUB_RUN) || (state_i == ST_SWITCH);
  assign per_clk_en_o  = cpu_clk_en_o || sleeping;
  assign main_osc_en_o = (state_i == ST_MAIN_WAIT) || (state_i == ST_MAIN_RUN) ||
                         (state_i == ST_SWITCH) || (sleeping && scm_i);
  assign sub_osc_en_o  = (state_i == ST_SUB_WAIT) || (state_i == ST_SUB_RUN) ||
                         (state_i == ST_SWITCH) || (sleeping && !scm_i);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int MAIN_STAB_TICKS = 16,
  parameter int SUB_STAB_TICKS  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       por_sub_i,
  input  logic       ext_rst_i,
  input  logic       sw_rst_i,
  input  logic       wdt_rst_i,
  input  logic       wr_i,
  input  logic       wr_scs_i,
  input  logic       wr_slp_i,
  input  logic       wr_stp_i,
  input  logic       irq_i,
  output logic       main_osc_en_o,
  output logic       sub_osc_en_o,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       scm_o,
  output logic [2:0] state_o
);
  localparam int MAX_TICKS = (MAIN_STAB_TICKS > SUB_STAB_TICKS) ? MAIN_STAB_TICKS : SUB_STAB_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] MAIN_LIM = CNT_W'(MAIN_STAB_TICKS);
  localparam logic [CNT_W-1:0] SUB_LIM  = CNT_W'(SUB_STAB_TICKS);

  pmc_state_e       state_q, state_d;
  logic             scm_q, scm_d;
  logic             rst_req, wait_active, stab_done;
  logic [CNT_W-1:0] limit;

  assign rst_req     = ext_rst_i || sw_rst_i || wdt_rst_i;
  assign wait_active = (state_q == ST_MAIN_WAIT) || (state_q == ST_SUB_WAIT) || (state_q == ST_SWITCH);
  assign limit       = (state_q == ST_SUB_WAIT) ? SUB_LIM : MAIN_LIM;

  pmc_stab_cnt #(.CNT_W(CNT_W)) u_stab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (wait_active),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (stab_done)
  );

  pmc_gate_dec u_gate (
    .state_i       (state_q),
    .scm_i         (scm_q),
    .main_osc_en_o (main_osc_en_o),
    .sub_osc_en_o  (sub_osc_en_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .per_clk_en_o  (per_clk_en_o)
  );

  always_comb begin
    state_d = state_q;
    scm_d   = scm_q;
    if (rst_req) begin
      state_d = ST_RESET;
      scm_d   = 1'b0;
    end else begin
      case (state_q)
        ST_RESET:     state_d = por_sub_i ? ST_SUB_WAIT : ST_MAIN_WAIT;
        ST_MAIN_WAIT: if (stab_done) begin state_d = ST_MAIN_RUN; scm_d = 1'b1; end
        ST_SUB_WAIT:  if (stab_done) begin state_d = ST_SUB_RUN;  scm_d = 1'b0; end
        ST_MAIN_RUN: if (wr_i) begin
          if (wr_stp_i)      state_d = ST_STOP;
          else if (wr_slp_i) state_d = ST_SLEEP;
          else if (!wr_scs_i) begin state_d = ST_SUB_RUN; scm_d = 1'b0; end
        end
        ST_SUB_RUN: if (wr_i) begin
          if (wr_stp_i)      state_d = ST_STOP;
          else if (wr_slp_i) state_d = ST_SLEEP;
          else if (wr_scs_i) state_d = ST_SWITCH;
        end
        ST_SWITCH:    if (stab_done) begin state_d = ST_MAIN_RUN; scm_d = 1'b1; end
        ST_SLEEP:     if (irq_i) state_d = scm_q ? ST_MAIN_RUN : ST_SUB_RUN;
        ST_STOP:      if (irq_i) state_d = scm_q ? ST_MAIN_WAIT : ST_SUB_WAIT;
        default:      state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      scm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      scm_q   <= scm_d;
    end
  end

  assign scm_o   = scm_q;
  assign state_o = state_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_i,
  input logic       sw_rst_i,
  input logic       wdt_rst_i,
  input logic       irq_i,
  input logic       main_osc_en_o,
  input logic       sub_osc_en_o,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       scm_o,
  input logic [2:0] state_o
);
  logic rreq;
  assign rreq = ext_rst_i || sw_rst_i || wdt_rst_i;

  assert_reset_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rreq |=> (state_o == 3'd0) && !scm_o);

  assert_wait_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 || state_o == 3'd2) |-> !cpu_clk_en_o && !per_clk_en_o);

  assert_no_direct_main_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |=> (state_o != 3'd3));

  assert_main_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |-> scm_o);

  assert_sleep_gates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6) |-> !cpu_clk_en_o && per_clk_en_o &&
                          (main_osc_en_o == scm_o) && (sub_osc_en_o == !scm_o));

  assert_wake_sleep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6 && irq_i && !rreq) |=> (state_o == ($past(scm_o) ? 3'd3 : 3'd4)));

  assert_stop_dark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd7) |-> !main_osc_en_o && !sub_osc_en_o && !cpu_clk_en_o && !per_clk_en_o);

  assert_cpu_needs_osc_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> (main_osc_en_o || sub_osc_en_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_rst_i     (ext_rst_i),
  .sw_rst_i      (sw_rst_i),
  .wdt_rst_i     (wdt_rst_i),
  .irq_i         (irq_i),
  .main_osc_en_o (main_osc_en_o),
  .sub_osc_en_o  (sub_osc_en_o),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .per_clk_en_o  (per_clk_en_o),
  .scm_o         (scm_o),
  .state_o       (state_o)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int MT = 5;
  localparam int SBT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 0, por_sub = 0, ext = 0, sw = 0, wdt = 0;
  logic wr = 0, scs = 0, slp = 0, stp = 0, irq = 0;
  logic mo, so, cpu, per, scm;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [2:0] m_state = 3'd0;
  logic       m_scm = 1'b0;
  int         m_cnt = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.MAIN_STAB_TICKS(MT), .SUB_STAB_TICKS(SBT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .por_sub_i(por_sub),
    .ext_rst_i(ext), .sw_rst_i(sw), .wdt_rst_i(wdt),
    .wr_i(wr), .wr_scs_i(scs), .wr_slp_i(slp), .wr_stp_i(stp), .irq_i(irq),
    .main_osc_en_o(mo), .sub_osc_en_o(so), .cpu_clk_en_o(cpu), .per_clk_en_o(per),
    .scm_o(scm), .state_o(state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected gates from R12
  function automatic logic [3:0] exp_gates(input logic [2:0] st, input logic sc);
    logic c, p, m, s;
    c = (st == 3'd3) || (st == 3'd4) || (st == 3'd5);
    p = c || (st == 3'd6);
    m = (st == 3'd1) || (st == 3'd3) || (st == 3'd5) || ((st == 3'd6) && sc);
    s = (st == 3'd2) || (st == 3'd4) || (st == 3'd5) || ((st == 3'd6) && !sc);
    return {m, s, c, p};
  endfunction

  task automatic model_step();
    logic [2:0] ns;
    logic nscm, waitst, done;
    int lim, ncnt;
    if (!rst_ni) begin
      m_state = 3'd0; m_scm = 1'b0; m_cnt = 0;
      return;
    end
    lim    = (m_state == 3'd2) ? SBT : MT;
    waitst = (m_state == 3'd1) || (m_state == 3'd2) || (m_state == 3'd5);
    done   = (m_cnt >= lim);
    ncnt   = !waitst ? 0 : ((tick && !done) ? m_cnt + 1 : m_cnt);
    ns = m_state; nscm = m_scm;
    if (ext || sw || wdt) begin
      ns = 3'd0; nscm = 1'b0;
    end else begin
      case (m_state)
        3'd0: ns = por_sub ? 3'd2 : 3'd1;
        3'd1: if (done) begin ns = 3'd3; nscm = 1'b1; end
        3'd2: if (done) begin ns = 3'd4; nscm = 1'b0; end
        3'd3: if (wr) begin
          if (stp) ns = 3'd7; else if (slp) ns = 3'd6;
          else if (!scs) begin ns = 3'd4; nscm = 1'b0; end
        end
        3'd4: if (wr) begin
          if (stp) ns = 3'd7; else if (slp) ns = 3'd6; else if (scs) ns = 3'd5;
        end
        3'd5: if (done) begin ns = 3'd3; nscm = 1'b1; end
        3'd6: if (irq) ns = m_scm ? 3'd3 : 3'd4;
        default: if (irq) ns = m_scm ? 3'd1 : 3'd2;
      endcase
    end
    m_state = ns; m_scm = nscm; m_cnt = ncnt;
  endtask

  task automatic compare();
    logic [3:0] g;
    g = exp_gates(m_state, m_scm);
    chk(state == m_state, "R1 model state", int'(state), int'(m_state));
    chk(scm == m_scm, "R7 model scm", int'(scm), int'(m_scm));
    chk({mo, so, cpu, per} == g, "R12 model gates", int'({mo, so, cpu, per}), int'(g));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % 3) cyc();
      tick = 1'b1; cyc(); tick = 1'b0;
    end
  endtask

  task automatic wr_req(input logic c, input logic l, input logic p);
    wr = 1'b1; scs = c; slp = l; stp = p;
    cyc();
    wr = 1'b0; scs = 1'b0; slp = 1'b0; stp = 1'b0;
  endtask

  task automatic pulse_irq();
    irq = 1'b1; cyc(); irq = 1'b0;
  endtask

  task automatic st_is(input logic [2:0] e, input string tag);
    chk(state == e, tag, int'(state), int'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    st_is(3'd0, "R1 reset state");
    chk({mo, so, cpu, per, scm} == 5'b0, "R1 reset outputs", int'({mo, so, cpu, per, scm}), 0);

    rst_ni = 1'b1;
    cyc();
    st_is(3'd1, "R2 main wait after reset");
    chk(!cpu && mo, "R2 gated, main osc on", int'({mo, cpu}), 2);
    tick_n(MT - 1);
    st_is(3'd1, "R3 still waiting before last tick");
    tick_n(1);
    st_is(3'd1, "R3 done, transition on next edge");
    cyc();
    st_is(3'd3, "R3 main run reached");
    chk(scm, "R7 scm in main run", int'(scm), 1);

    pulse_irq(); tick_n(2);
    st_is(3'd3, "R11 irq and tick ignored in run");

    wr_req(1'b0, 1'b0, 1'b0);
    st_is(3'd4, "R5 main to sub");
    chk(!scm && so && !mo, "R5 scm clear, sub osc", int'({scm, so, mo}), 2);

    wr_req(1'b1, 1'b0, 1'b0);
    st_is(3'd5, "R6 switch pending");
    chk(!scm && cpu && mo && so, "R6 switch runs on sub", int'({scm, cpu, mo, so}), 7);
    wr_req(1'b0, 1'b1, 1'b0);
    st_is(3'd5, "R11 write ignored in switch");
    tick_n(MT);
    cyc();
    st_is(3'd3, "R6 switch complete");
    chk(scm, "R6 scm set", int'(scm), 1);

    wr_req(1'b1, 1'b1, 1'b0);
    st_is(3'd6, "R10 sleep wins over select");
    chk(!cpu && per && mo, "R8 sleep gates from main", int'({cpu, per, mo}), 3);
    pulse_irq();
    st_is(3'd3, "R8 wake to main run");
    cyc();
    st_is(3'd3, "R10 no re-entry after wake");

    wr_req(1'b0, 1'b0, 1'b0);
    wr_req(1'b0, 1'b1, 1'b0);
    st_is(3'd6, "R8 sleep from sub");
    chk(so && !mo, "R8 sub osc kept", int'({so, mo}), 2);
    pulse_irq();
    st_is(3'd4, "R8 wake to sub run");

    wr_req(1'b1, 1'b1, 1'b1);
    st_is(3'd7, "R10 stop wins over sleep");
    tick_n(4);
    st_is(3'd7, "R11 tick ignored in stop");
    pulse_irq();
    st_is(3'd2, "R9 stop wakes to sub wait");
    tick_n(SBT - 1);
    chk(!cpu, "R9 cpu held during wait", int'(cpu), 0);
    tick_n(1); cyc();
    st_is(3'd4, "R9 sub run after delay");

    wr_req(1'b1, 1'b0, 1'b0);
    tick_n(2);
    ext = 1'b1; cyc();
    st_is(3'd0, "R4 reset cancels switch");
    cyc();
    st_is(3'd0, "R4 held while request high");
    ext = 1'b0; cyc();
    st_is(3'd1, "R4 resume to main wait");
    tick_n(MT - 1);
    st_is(3'd1, "R3 count restarted");
    tick_n(1); cyc();

    wr_req(1'b0, 1'b0, 1'b1);
    pulse_irq();
    st_is(3'd1, "R9 stop from main wakes to main wait");
    chk(scm, "R7 scm kept through stop", int'(scm), 1);
    tick_n(MT); cyc();
    st_is(3'd3, "R9 main run after delay");

    wr_req(1'b0, 1'b1, 1'b0);
    sw = 1'b1; cyc(); sw = 1'b0;
    st_is(3'd0, "R4 software reset from sleep");
    por_sub = 1'b1; cyc();
    st_is(3'd2, "R2 sub wait when por_sub set");
    tick_n(SBT); cyc();
    st_is(3'd4, "R3 sub run after sub delay");
    wdt = 1'b1; cyc(); wdt = 1'b0;
    st_is(3'd0, "R4 watchdog reset from sub run");
    por_sub = 1'b0;

    for (int it = 0; it < 1500; it++) begin
      int r;
      r = $urandom % 40;
      tick = ($urandom % 2) == 1;
      irq  = ($urandom % 5) == 0;
      if (r == 0) begin
        ext = ($urandom % 3) == 0; sw = !ext && ($urandom % 2); wdt = !ext && !sw;
        por_sub = $urandom % 2;
      end else if (r < 8) begin
        wr = 1'b1; scs = $urandom % 2; slp = ($urandom % 4) == 0; stp = ($urandom % 5) == 0;
      end
      cyc();
      ext = 0; sw = 0; wdt = 0; wr = 0; scs = 0; slp = 0; stp = 0; tick = 0; irq = 0;
    end

    rst_ni = 1'b0;
    @(negedge clk);
    m_state = 3'd0; m_scm = 1'b0; m_cnt = 0;
    st_is(3'd0, "R1 power-on reset again");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule